// File: doc/BRIEF.md
# Management-Frame PHY Register Model

This block stands in for one Ethernet PHY behind a single 32-bit management-frame register. Software writes a frame word that says whether it reads or writes, which PHY and PHY register it targets, and 16 bits of data. The block carries out the access against a small bank of PHY registers at once. On a read, the block returns the register value in the low half of the frame register. Every accepted frame write produces a one-cycle completion pulse.

The registers are control, status, advertisement, a latched interrupt-source register and an interrupt mask. Writes go through per-register masks, and some bits are forced to fixed values. Setting the auto-negotiation enable bit completes negotiation at once. A link-state input is watched for edges. Each edge updates the status bits and latches interrupt-source bits, which stay set until the source register is read.

Top module: `mii_phy_model`

## Requirements
- R1: After reset, control reads 0x3000, status 0x7809, advertisement 0x01E1, interrupt source 0 and interrupt mask 0. `frame_o` is 0 and `done_o` is low.
- R2: The frame word is decoded as follows. Bit 29 set means read and bit 29 clear means write. Bits 27:23 give the PHY address, bits 22:18 the register number and bits 15:0 the data.
- R3: A frame write is stored in `frame_o` on the next clock edge. For a read, bits 15:0 are replaced by the addressed register's value from before that edge. All other bits keep the written value.
- R4: `done_o` is high in the cycle after each frame write, for either a read or a write. It is low in the cycle after a clock edge with no frame write.
- R5: A write to register 0 stores data AND 0x7980. If data bit 12 is set, status bit 5 (0x0020) becomes set on the same edge.
- R6: A write to register 4 stores (data AND 0x2D7F) OR 0x0080. A write to register 30 stores data AND 0x00FF.
- R7: A rising edge of `link_up_i` sets status bits 0x0024 and latches interrupt-source bits 7 and 6. A falling edge clears status bits 0x0024 and latches interrupt-source bit 4. A level that is held creates no further events. A link edge overrides a status update from a write on the same cycle.
- R8: Registers 5, 6 and all register numbers not named here read as 0. Writes to registers 1, 29 and unnamed numbers are ignored. Register 29 reads the latched sources and register 30 reads the mask.
- R9: A read of register 29 returns the latched bits and clears them on the same edge. Bits latched by a link edge on that same edge are kept.
- R10: Only PHY address 0 (parameter `RESP_ADDR`) responds. For any other address, reads return 0 and writes change no register, but `done_o` still pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Frame register write strobe |
| wr_data_i | input | 32 | Frame word |
| link_up_i | input | 1 | Link state level, 1 = up |
| frame_o | output | 32 | Frame register contents |
| done_o | output | 1 | Operation complete pulse |

## Verification
The bench builds the block with its default parameters. The responding address is 0, so any nonzero address in bits 27:23 exercises the path that must ignore the access. This default also means one vector table can cover every register number, both masks with forced bits, and the upper-bit pass-through of read frames. Directed steps then drive both link edges, hold the link level, and make a source-register read coincide with a link edge.

// File: rtl/mii_phy_pkg.sv
package mii_phy_pkg;
  parameter int FRAME_W   = 32;
  parameter int DATA_W    = 16;
  parameter int ADDR_W    = 5;
  parameter int REGN_W    = 5;
  parameter int RD_BIT    = 29;
  localparam int REGN_LSB = 18;
  localparam int ADDR_LSB = REGN_LSB + REGN_W;
  localparam int HI_W     = FRAME_W - DATA_W;

  localparam logic [REGN_W-1:0] REG_CTL  = 5'd0;
  localparam logic [REGN_W-1:0] REG_STS  = 5'd1;
  localparam logic [REGN_W-1:0] REG_ADV  = 5'd4;
  localparam logic [REGN_W-1:0] REG_ISRC = 5'd29;
  localparam logic [REGN_W-1:0] REG_IMSK = 5'd30;

  localparam logic [DATA_W-1:0] CTL_RST  = 16'h3000;
  localparam logic [DATA_W-1:0] STS_RST  = 16'h7809;
  localparam logic [DATA_W-1:0] ADV_RST  = 16'h01E1;
  localparam logic [DATA_W-1:0] CTL_MASK = 16'h7980;
  localparam logic [DATA_W-1:0] ADV_MASK = 16'h2D7F;
  localparam logic [DATA_W-1:0] ADV_SET  = 16'h0080;
  localparam logic [DATA_W-1:0] IMSK_MSK = 16'h00FF;
  localparam logic [DATA_W-1:0] STS_AN   = 16'h0020;
  localparam logic [DATA_W-1:0] STS_LINK = 16'h0024;
  localparam logic [DATA_W-1:0] ISRC_UP  = 16'h00C0;
  localparam logic [DATA_W-1:0] ISRC_DN  = 16'h0010;
  localparam int                AN_EN    = 12;

  typedef struct packed {
    logic              rd;
    logic [ADDR_W-1:0] phy;
    logic [REGN_W-1:0] regn;
    logic [DATA_W-1:0] data;
  } mgmt_op_t;
endpackage

// File: rtl/mii_mgmt_decode.sv
module mii_mgmt_decode
  import mii_phy_pkg::*;
#(
  parameter logic [ADDR_W-1:0] RESP_ADDR = '0
) (
  input  logic [FRAME_W-1:0] frame_i,
  output mgmt_op_t           op_o,
  output logic               hit_o,
  output logic [HI_W-1:0]    hi_o
);
  always_comb begin
    op_o.rd   = frame_i[RD_BIT];
    op_o.phy  = frame_i[ADDR_LSB +: ADDR_W];
    op_o.regn = frame_i[REGN_LSB +: REGN_W];
    op_o.data = frame_i[DATA_W-1:0];
  end
  assign hit_o = (op_o.phy == RESP_ADDR);
  assign hi_o  = frame_i[FRAME_W-1:DATA_W];
endmodule

// File: rtl/mii_link_mon.sv
module mii_link_mon (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic link_i,
  output logic up_evt_o,
  output logic dn_evt_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= link_i;
  end

  assign up_evt_o = link_i & ~prev_q;
  assign dn_evt_o = ~link_i & prev_q;

  // R7: edges are exclusive
  a_r7_one_event: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(up_evt_o && dn_evt_o));
  // R7: held level gives no repeat event
  a_r7_no_repeat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    up_evt_o |=> !up_evt_o);
endmodule

// File: rtl/mii_phy_regs.sv
module mii_phy_regs
  import mii_phy_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              acc_i,
  input  mgmt_op_t          op_i,
  input  logic              hit_i,
  input  logic              up_evt_i,
  input  logic              dn_evt_i,
  output logic [DATA_W-1:0] rd_data_o
);
  logic [DATA_W-1:0] ctl_q, sts_q, adv_q, isrc_q, imsk_q;
  logic [DATA_W-1:0] sts_d, isrc_d;
  logic              wr_acc, rd_isrc;

  assign wr_acc  = acc_i & hit_i & ~op_i.rd;
  assign rd_isrc = acc_i & hit_i & op_i.rd & (op_i.regn == REG_ISRC);

  always_comb begin
    rd_data_o = '0;
    if (hit_i) begin
      case (op_i.regn)
        REG_CTL:  rd_data_o = ctl_q;
        REG_STS:  rd_data_o = sts_q;
        REG_ADV:  rd_data_o = adv_q;
        REG_ISRC: rd_data_o = isrc_q;
        REG_IMSK: rd_data_o = imsk_q;
        default:  rd_data_o = '0;
      endcase
    end
  end

  // link edge applied after write effect so it wins
  always_comb begin
    sts_d = sts_q;
    if (wr_acc && op_i.regn == REG_CTL && op_i.data[AN_EN]) sts_d = sts_d | STS_AN;
    if (up_evt_i) sts_d = sts_d | STS_LINK;
    if (dn_evt_i) sts_d = sts_d & ~STS_LINK;
    isrc_d = rd_isrc ? '0 : isrc_q;
    if (up_evt_i) isrc_d = isrc_d | ISRC_UP;
    if (dn_evt_i) isrc_d = isrc_d | ISRC_DN;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q  <= CTL_RST;
      sts_q  <= STS_RST;
      adv_q  <= ADV_RST;
      isrc_q <= '0;
      imsk_q <= '0;
    end else begin
      sts_q  <= sts_d;
      isrc_q <= isrc_d;
      if (wr_acc) begin
        case (op_i.regn)
          REG_CTL:  ctl_q  <= op_i.data & CTL_MASK;
          REG_ADV:  adv_q  <= (op_i.data & ADV_MASK) | ADV_SET;
          REG_IMSK: imsk_q <= op_i.data & IMSK_MSK;
          default:  ;
        endcase
      end
    end
  end

  a_r5_autoneg_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_acc && op_i.regn == REG_CTL && op_i.data[AN_EN] && !dn_evt_i) |=> sts_q[5]);
  a_r6_adv_forced: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_acc && op_i.regn == REG_ADV) |=> adv_q[7]);
  a_r7_link_up: assert property (@(posedge clk_i) disable iff (!rst_ni)
    up_evt_i |=> ((sts_q & STS_LINK) == STS_LINK) && isrc_q[7] && isrc_q[6]);
  a_r7_link_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dn_evt_i |=> ((sts_q & STS_LINK) == '0) && isrc_q[4]);
  a_r9_read_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_isrc && !up_evt_i && !dn_evt_i) |=> (isrc_q == '0));
  a_r10_foreign_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_i && !hit_i) |=> ($stable(ctl_q) && $stable(adv_q) && $stable(imsk_q)));
endmodule

// File: rtl/mii_phy_model.sv
module mii_phy_model
  import mii_phy_pkg::*;
#(
  parameter logic [ADDR_W-1:0] RESP_ADDR = '0
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [FRAME_W-1:0] wr_data_i,
  input  logic               link_up_i,
  output logic [FRAME_W-1:0] frame_o,
  output logic               done_o
);
  mgmt_op_t          op;
  logic              hit;
  logic [HI_W-1:0]   hi;
  logic [DATA_W-1:0] rd_data;
  logic              up_evt, dn_evt;
  logic [FRAME_W-1:0] frame_q;
  logic              done_q;

  mii_mgmt_decode #(.RESP_ADDR(RESP_ADDR)) i_dec (
    .frame_i (wr_data_i),
    .op_o    (op),
    .hit_o   (hit),
    .hi_o    (hi)
  );

  mii_link_mon i_link (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .link_i   (link_up_i),
    .up_evt_o (up_evt),
    .dn_evt_o (dn_evt)
  );

  mii_phy_regs i_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .acc_i     (wr_en_i),
    .op_i      (op),
    .hit_i     (hit),
    .up_evt_i  (up_evt),
    .dn_evt_i  (dn_evt),
    .rd_data_o (rd_data)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frame_q <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= wr_en_i;
      if (wr_en_i) frame_q <= op.rd ? {hi, rd_data} : wr_data_i;
    end
  end

  assign frame_o = frame_q;
  assign done_o  = done_q;

  a_r4_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> done_o);
  a_r4_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> !done_o);
  a_r3_upper_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> (frame_o[FRAME_W-1:DATA_W] == $past(wr_data_i[FRAME_W-1:DATA_W])));
  a_r10_foreign_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && op.rd && !hit) |=> (frame_o[DATA_W-1:0] == '0));
endmodule

// File: tb/test_mii_phy_model.sv
`timescale 1ns/1ps
module test_mii_phy_model;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        link_up = 1'b0;
  logic [31:0] frame;
  logic        done;
  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  mii_phy_model i_mii_phy_model (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .link_up_i(link_up), .frame_o(frame), .done_o(done)
  );

  // R2 layout: bit29 read, 27:23 phy address, 22:18 register, 15:0 data
  function automatic logic [31:0] mk(input logic rd, input logic [4:0] ad,
                                     input logic [4:0] rg, input logic [15:0] d);
    return {2'b00, rd, 1'b0, ad, rg, 2'b00, d};
  endfunction

  localparam int N = 24;
  localparam logic [31:0] V_IN [N] = '{
    mk(1,0,0,16'hABCD),                   // R1 R3 control reset
    mk(1,0,1,16'h0) | 32'h8001_0000,      // R1 R3 status reset, upper bits kept
    mk(1,0,4,16'h0),                      // R1 advert reset
    mk(1,0,29,16'h0),                     // R1
    mk(1,0,30,16'h0),                     // R1
    mk(0,0,4,16'hFFFF),                   // R6
    mk(1,0,4,16'h0),                      // R6
    mk(0,0,0,16'hFFFF),                   // R5
    mk(1,0,0,16'h0),                      // R5
    mk(1,0,1,16'h0),                      // R5 autoneg complete
    mk(0,0,30,16'h1234),                  // R6
    mk(1,0,30,16'h0),                     // R6
    mk(0,0,1,16'h0000),                   // R8 status read-only
    mk(1,0,1,16'h0),                      // R8
    mk(1,0,5,16'h0),                      // R8
    mk(1,0,6,16'h0),                      // R8
    mk(1,0,2,16'h0),                      // R8
    mk(1,3,0,16'h0),                      // R10 foreign read
    mk(0,3,0,16'h0000),                   // R10 foreign write
    mk(1,0,0,16'h0),                      // R10
    mk(0,3,30,16'h00FF),                  // R10
    mk(1,0,30,16'h0),                     // R10
    mk(0,0,0,16'h0000),                   // R5 enable off
    mk(1,0,1,16'h0)                       // R5 status keeps bit 5
  };
  localparam logic [31:0] V_EXP [N] = '{
    mk(1,0,0,16'h3000),
    mk(1,0,1,16'h7809) | 32'h8001_0000,
    mk(1,0,4,16'h01E1),
    mk(1,0,29,16'h0),
    mk(1,0,30,16'h0),
    mk(0,0,4,16'hFFFF),
    mk(1,0,4,16'h2DFF),
    mk(0,0,0,16'hFFFF),
    mk(1,0,0,16'h7980),
    mk(1,0,1,16'h7829),
    mk(0,0,30,16'h1234),
    mk(1,0,30,16'h0034),
    mk(0,0,1,16'h0000),
    mk(1,0,1,16'h7829),
    mk(1,0,5,16'h0),
    mk(1,0,6,16'h0),
    mk(1,0,2,16'h0),
    mk(1,3,0,16'h0),
    mk(0,3,0,16'h0000),
    mk(1,0,0,16'h7980),
    mk(0,3,30,16'h00FF),
    mk(1,0,30,16'h0034),
    mk(0,0,0,16'h0000),
    mk(1,0,1,16'h7829)
  };
  localparam int V_REQ [N] = '{1,1,1,1,1,6,6,5,5,5,6,6,8,8,8,8,8,10,10,10,10,10,5,5};

  task automatic chk(input logic [31:0] got, input logic [31:0] exp, input int r,
                     input string what);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL R%0d %s: actual %h expected %h", r, what, got, exp);
    end
  endtask

  // R4 pulse checked on every operation: high one cycle, then low
  task automatic op(input logic [31:0] w, input logic [31:0] exp, input int r);
    @(negedge clk); wr_en = 1'b1; wr_data = w;
    @(negedge clk); wr_en = 1'b0;
    chk(frame, exp, r, "frame");
    chk({31'b0, done}, 32'd1, 4, "done high");
    @(negedge clk);
    chk({31'b0, done}, 32'd0, 4, "done low");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(frame, 32'h0, 1, "frame in reset");
    chk({31'b0, done}, 32'd0, 1, "done in reset");
    rst_n = 1'b1;
    @(negedge clk);
    chk(frame, 32'h0, 1, "frame after reset");

    for (int i = 0; i < N; i++) op(V_IN[i], V_EXP[i], V_REQ[i]);

    // R7 link up
    @(negedge clk); link_up = 1'b1;
    repeat (2) @(negedge clk);
    op(mk(1,0,1,0), mk(1,0,1,16'h782D), 7);
    op(mk(1,0,29,0), mk(1,0,29,16'h00C0), 7);
    // R9 cleared by the read
    op(mk(1,0,29,0), mk(1,0,29,16'h0000), 9);
    // R7 held level, no new event
    repeat (4) @(negedge clk);
    op(mk(1,0,29,0), mk(1,0,29,16'h0000), 7);

    // R9 source read on the same edge as a link-down edge
    @(negedge clk); wr_en = 1'b1; wr_data = mk(1,0,29,0); link_up = 1'b0;
    @(negedge clk); wr_en = 1'b0;
    chk(frame, mk(1,0,29,16'h0000), 9, "read at link edge");
    @(negedge clk);
    op(mk(1,0,29,0), mk(1,0,29,16'h0010), 9);
    op(mk(1,0,1,0), mk(1,0,1,16'h7809), 7);

    // R7 link edge overrides autoneg write on the same edge
    @(negedge clk); link_up = 1'b1;
    @(negedge clk);
    @(negedge clk); wr_en = 1'b1; wr_data = mk(0,0,0,16'h1000); link_up = 1'b0;
    @(negedge clk); wr_en = 1'b0;
    @(negedge clk);
    op(mk(1,0,1,0), mk(1,0,1,16'h7809), 7);
    op(mk(1,0,0,0), mk(1,0,0,16'h1000), 5);

    // R1 reset mid-run
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    chk(frame, 32'h0, 1, "frame after re-reset");
    rst_n = 1'b1;
    op(mk(1,0,0,0), mk(1,0,0,16'h3000), 1);
    op(mk(1,0,29,0), mk(1,0,29,16'h0000), 1);
    op(mk(1,0,30,0), mk(1,0,30,16'h0000), 1);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule